// File: doc/BRIEF.md
# Legacy Graphics Window Translator

This block sits between a host port and a four-plane display memory. It takes one host byte access inside the 128 KB legacy graphics window and produces three things: a display-memory address, the plane write enables, and a hit/miss verdict. Four window modes select which part of the host window is live. One of them is a banked lower half that adds a programmable bank base. Addressing is then steered in one of three ways:

- **Packed byte mode:** the low two address bits pick the plane.
- **Interleaved text mode:** the even/odd address bit together with a read-map bit pick the plane.
- **Latched planar mode:** the access is handed on as a 32-bit word index for the planar datapath.

Requests arrive on a valid/ready channel. Each request produces one registered response on a second valid/ready channel. A request is accepted only when the response slot is empty or is being drained in the same cycle. While `rsp_ready` is low, a pending response holds every field stable and `req_ready` stays low. Control fields and the bank base are sampled in the cycle a request is accepted. Each plane has a sticky "updated" flag that records performed writes until a synchronous clear.

Top module: `gfx_aperture`

## Requirements
- R1: Only the low WIN_AW bits of `req_addr` take part in decoding; the host bits above them have no effect on any response field.
- R2: With `win_sel`=0 every window offset hits, and the offset is the masked address unchanged.
- R3: With `win_sel`=1 only offsets below 2^(WIN_AW-1) hit. The offset is the masked address plus the bank base, modulo 2^VRAM_AW. The bank base is a register written through `bank_wr_en`/`bank_wr_data` and is used from the cycle after that write.
- R4: With `win_sel`=2 the offset is the address minus 2^(WIN_AW-1), and with `win_sel`=3 it is the address minus 3·2^(WIN_AW-2). In both modes the access hits only when the result is below 2^(WIN_AW-2).
- R5: A miss gives `rsp_hit`=0 and `rsp_plane_we`=0. A read miss returns `rsp_data`=8'hFF.
- R6: With `chain4_en`=1 the plane is offset bits [1:0] and `rsp_addr` is the offset itself.
- R7: With `chain4_en`=0 and `oddeven_en`=1 the plane is {`read_map`[1], offset bit 0}, and `rsp_addr` is ((offset with bit 0 cleared)·2) OR plane, modulo 2^VRAM_AW.
- R8: With both modes off, `rsp_latched`=1 and `rsp_addr` is the offset used as a word index. A write hit then enables every plane whose `map_mask` bit is set.
- R9: In chain-4 and odd/even modes a write hit enables only the selected plane, and only when that plane's `map_mask` bit is set.
- R10: A read never raises a plane write enable. A write response carries `req_wdata` in `rsp_data`, and a read hit carries 8'h00.
- R11: Each plane write enable issued sets that plane's `plane_updated` bit in the cycle of acceptance. The bits never drop except when `upd_clr` is high, which zeroes all of them on the next edge.
- R12: While `rsp_valid`=1 and `rsp_ready`=0, `req_ready` is 0 and the response fields stay unchanged. After reset `rsp_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_wr_en | input | 1 | Load the bank base register |
| bank_wr_data | input | VRAM_AW | New bank base |
| win_sel | input | 2 | Window mode 0..3 |
| chain4_en | input | 1 | Packed byte (chain-4) addressing |
| oddeven_en | input | 1 | Interleaved text addressing |
| read_map | input | 2 | Read-map select; bit 1 steers odd/even plane |
| map_mask | input | 4 | Plane write mask, bit n = plane n |
| upd_clr | input | 1 | Clear sticky updated flags |
| req_valid | input | 1 | Host access present |
| req_ready | output | 1 | Access accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | HOST_AW | Host byte address |
| req_wdata | input | 8 | Write data byte |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes response |
| rsp_write | output | 1 | Response belongs to a write |
| rsp_hit | output | 1 | Access fell inside the live window |
| rsp_latched | output | 1 | Planar latched access, address is word index |
| rsp_addr | output | VRAM_AW | Translated display-memory address |
| rsp_plane_we | output | 4 | Per-plane write enables |
| rsp_data | output | 8 | Write data, or 8'hFF on read miss |
| plane_updated | output | 4 | Sticky per-plane written flags |

## Verification
The bench builds the block with HOST_AW=10, WIN_AW=9 and VRAM_AW=11. This shrinks the window to 512 bytes, so every window offset can be swept in every window mode, every addressing style, and both access directions. It also reaches one junk host bit above the window, and a bank base large enough that the banked sum wraps. Mask and read-map values are varied with the address, so every plane-steering case meets both set and clear mask bits. The sticky flags are tracked across the whole sweep, and a back-pressure sequence holds and then releases the response slot.

// File: rtl/gfx_aperture_pkg.sv
package gfx_aperture_pkg;
  localparam int NPL = 4;

  typedef enum logic [1:0] {
    WIN_FULL   = 2'd0,
    WIN_BANKED = 2'd1,
    WIN_MID    = 2'd2,
    WIN_TOP    = 2'd3
  } win_mode_e;
endpackage

// File: rtl/gfx_window_map.sv
module gfx_window_map #(
  parameter int WIN_AW  = 17,
  parameter int VRAM_AW = 19
) (
  input  logic [WIN_AW-1:0]  win_addr,
  input  logic [1:0]         mode,
  input  logic [VRAM_AW-1:0] bank,
  output logic               hit,
  output logic [VRAM_AW-1:0] off
);
  import gfx_aperture_pkg::*;

  localparam logic [VRAM_AW-1:0] HALF = VRAM_AW'(1) << (WIN_AW - 1);
  localparam logic [VRAM_AW-1:0] QTR  = VRAM_AW'(1) << (WIN_AW - 2);

  logic [VRAM_AW-1:0] wide;
  assign wide = VRAM_AW'(win_addr);

  always_comb begin
    unique case (win_mode_e'(mode))
      WIN_FULL: begin
        off = wide;
        hit = 1'b1;
      end
      WIN_BANKED: begin
        off = wide + bank;
        hit = !win_addr[WIN_AW-1];
      end
      WIN_MID: begin
        off = wide - HALF;
        hit = (off < QTR);
      end
      default: begin
        off = wide - (HALF + QTR);
        hit = (off < QTR);
      end
    endcase
  end
endmodule

// File: rtl/gfx_plane_steer.sv
module gfx_plane_steer #(
  parameter int VRAM_AW = 19
) (
  input  logic [VRAM_AW-1:0] off,
  input  logic               hit,
  input  logic               wr,
  input  logic               chain4,
  input  logic               oddeven,
  input  logic [1:0]         rmap,
  input  logic [3:0]         mask,
  output logic [VRAM_AW-1:0] addr,
  output logic               latched,
  output logic [3:0]         we
);
  logic [1:0] sel;

  always_comb begin
    latched = 1'b0;
    sel     = 2'd0;
    addr    = off;
    if (chain4) begin
      sel = off[1:0];
    end else if (oddeven) begin
      sel  = {rmap[1], off[0]};
      addr = {off[VRAM_AW-2:1], sel};
    end else begin
      latched = 1'b1;
    end
  end

  for (genvar p = 0; p < 4; p++) begin : g_we
    assign we[p] = wr && hit && mask[p] && (latched || (sel == 2'(p)));
  end
endmodule

// File: rtl/gfx_upd_flags.sv
module gfx_upd_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         set_en,
  input  logic [N-1:0] set_mask,
  output logic [N-1:0] flags
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) flags <= '0;
    else if (set_en)   flags <= flags | set_mask;
  end
endmodule

// File: rtl/gfx_aperture.sv
module gfx_aperture #(
  parameter int HOST_AW = 20,
  parameter int WIN_AW  = 17,
  parameter int VRAM_AW = 19
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bank_wr_en,
  input  logic [VRAM_AW-1:0] bank_wr_data,
  input  logic [1:0]         win_sel,
  input  logic               chain4_en,
  input  logic               oddeven_en,
  input  logic [1:0]         read_map,
  input  logic [3:0]         map_mask,
  input  logic               upd_clr,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [HOST_AW-1:0] req_addr,
  input  logic [7:0]         req_wdata,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic               rsp_write,
  output logic               rsp_hit,
  output logic               rsp_latched,
  output logic [VRAM_AW-1:0] rsp_addr,
  output logic [3:0]         rsp_plane_we,
  output logic [7:0]         rsp_data,
  output logic [3:0]         plane_updated
);
  import gfx_aperture_pkg::*;

  logic [VRAM_AW-1:0] bank_q;
  logic               hit_c, latched_c;
  logic [VRAM_AW-1:0] off_c, addr_c;
  logic [3:0]         we_c;
  logic               accept;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)          bank_q <= '0;
    else if (bank_wr_en) bank_q <= bank_wr_data;
  end

  gfx_window_map #(.WIN_AW(WIN_AW), .VRAM_AW(VRAM_AW)) u_map (
    .win_addr (req_addr[WIN_AW-1:0]),
    .mode     (win_sel),
    .bank     (bank_q),
    .hit      (hit_c),
    .off      (off_c)
  );

  gfx_plane_steer #(.VRAM_AW(VRAM_AW)) u_steer (
    .off     (off_c),
    .hit     (hit_c),
    .wr      (req_write),
    .chain4  (chain4_en),
    .oddeven (oddeven_en),
    .rmap    (read_map),
    .mask    (map_mask),
    .addr    (addr_c),
    .latched (latched_c),
    .we      (we_c)
  );

  gfx_upd_flags #(.N(NPL)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (upd_clr),
    .set_en   (accept),
    .set_mask (we_c),
    .flags    (plane_updated)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_write    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_latched  <= 1'b0;
      rsp_addr     <= '0;
      rsp_plane_we <= '0;
      rsp_data     <= '0;
    end else if (accept) begin
      rsp_valid    <= 1'b1;
      rsp_write    <= req_write;
      rsp_hit      <= hit_c;
      rsp_latched  <= latched_c;
      rsp_addr     <= addr_c;
      rsp_plane_we <= we_c;
      rsp_data     <= req_write ? req_wdata : (hit_c ? 8'h00 : 8'hFF);
    end else if (rsp_ready) begin
      rsp_valid    <= 1'b0;
    end
  end
endmodule

// File: rtl/gfx_aperture_chk.sv
module gfx_aperture_chk #(
  parameter int VRAM_AW = 19
) (
  input logic               clk,
  input logic               rst_n,
  input logic               upd_clr,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic               rsp_write,
  input logic               rsp_hit,
  input logic               rsp_latched,
  input logic [VRAM_AW-1:0] rsp_addr,
  input logic [3:0]         rsp_plane_we,
  input logic [3:0]         plane_updated
);
  p_miss_no_we_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_hit |-> rsp_plane_we == 4'd0);

  p_read_no_we_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_write |-> rsp_plane_we == 4'd0);

  p_steer_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_latched |-> $onehot0(rsp_plane_we));

  p_flags_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_clr |=> (plane_updated & $past(plane_updated)) == $past(plane_updated));

  p_flags_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    upd_clr |=> plane_updated == 4'd0);

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr) && $stable(rsp_plane_we)
      && $stable(rsp_hit));
endmodule

bind gfx_aperture gfx_aperture_chk #(.VRAM_AW(VRAM_AW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .upd_clr       (upd_clr),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_write     (rsp_write),
  .rsp_hit       (rsp_hit),
  .rsp_latched   (rsp_latched),
  .rsp_addr      (rsp_addr),
  .rsp_plane_we  (rsp_plane_we),
  .plane_updated (plane_updated)
);

// File: tb/test_gfx_aperture.sv
`timescale 1ns/1ps
module test_gfx_aperture;
  localparam int HA = 10;
  localparam int WA = 9;
  localparam int VA = 11;
  localparam int HALF = 1 << (WA - 1);
  localparam int QTR  = 1 << (WA - 2);
  localparam int VMOD = 1 << VA;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bank_wr_en = 1'b0;
  logic [VA-1:0] bank_wr_data = '0;
  logic [1:0]    win_sel = '0;
  logic          chain4_en = 1'b0, oddeven_en = 1'b0;
  logic [1:0]    read_map = '0;
  logic [3:0]    map_mask = '0;
  logic          upd_clr = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [HA-1:0] req_addr = '0;
  logic [7:0]    req_wdata = '0;
  logic          rsp_ready = 1'b1;
  logic          req_ready, rsp_valid, rsp_write, rsp_hit, rsp_latched;
  logic [VA-1:0] rsp_addr;
  logic [3:0]    rsp_plane_we, plane_updated;
  logic [7:0]    rsp_data;

  int n_chk = 0, n_bad = 0;
  logic [3:0] exp_upd = '0;
  int bank_val = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gfx_aperture #(.HOST_AW(HA), .WIN_AW(WA), .VRAM_AW(VA)) i_gfx_aperture (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic load_bank(input int b);
    @(negedge clk);
    req_valid = 1'b0;
    bank_wr_en = 1'b1; bank_wr_data = VA'(b);
    @(negedge clk);
    bank_wr_en = 1'b0;
    bank_val = b;
  endtask

  task automatic vec(input int mode, input int style, input bit wr, input int a);
    int off; bit hit; bit lat; int eaddr; int sel; logic [3:0] ewe; logic [7:0] edata;
    logic [3:0] msk; logic [1:0] rm; string tag; int host;
    msk  = 4'((a >> 2) ^ (a >> 5) ^ style);
    rm   = {a[6] ^ a[0], a[7]};
    host = a | (((a * 7) & 1) << WA);
    // expected window translation (R2, R3, R4)
    case (mode)
      0: begin off = a; hit = 1; end
      1: begin off = (a + bank_val) % VMOD; hit = (a < HALF); end
      2: begin off = (a - HALF + VMOD) % VMOD; hit = (off < QTR); end
      default: begin off = (a - HALF - QTR + VMOD) % VMOD; hit = (off < QTR); end
    endcase
    lat = (style == 2);
    sel = 0; eaddr = off;
    if (style == 0) sel = off & 3;
    else if (style == 1) begin
      sel = (rm[1] << 1) | (off & 1);
      eaddr = (((off & ~1) << 1) | sel) % VMOD;
    end
    ewe = '0;
    if (wr && hit) ewe = lat ? msk : (msk & 4'(1 << sel));
    edata = wr ? 8'(a ^ 8'h3C) : (hit ? 8'h00 : 8'hFF);
    if (!hit) tag = "R5";
    else if (style == 0) tag = "R6/R9";
    else if (style == 1) tag = "R7/R9";
    else tag = "R8";
    if (host >= (1 << WA)) tag = {tag, " R1"};
    if (mode == 1) tag = {tag, " R3"};
    else if (mode >= 2) tag = {tag, " R4"};
    else tag = {tag, " R2"};
    @(negedge clk);
    win_sel = 2'(mode); chain4_en = (style == 0); oddeven_en = (style == 1);
    read_map = rm; map_mask = msk; req_write = wr;
    req_addr = HA'(host); req_wdata = 8'(a ^ 8'h3C); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    exp_upd = exp_upd | ewe;
    chk({tag, " hit"}, rsp_hit, hit);
    chk({tag, " we"}, rsp_plane_we, ewe);
    chk({tag, " R10 data"}, rsp_data, edata);
    if (hit) begin
      chk({tag, " addr"}, rsp_addr, eaddr);
      chk({tag, " latched"}, rsp_latched, lat);
    end
    chk("R11 sticky", plane_updated, exp_upd);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 reset rsp_valid", rsp_valid, 0);
    chk("R12 reset req_ready", req_ready, 1);
    chk("R11 reset flags", plane_updated, 0);

    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 3; s++) begin
        load_bank(1900 + 37 * (m * 3 + s));
        for (int w = 0; w < 2; w++)
          for (int a = 0; a < (1 << WA); a++)
            vec(m, s, w[0], a);
      end
    end

    // R11: clear zeroes the flags
    @(negedge clk);
    upd_clr = 1'b1;
    @(negedge clk);
    upd_clr = 1'b0;
    exp_upd = '0;
    chk("R11 clear", plane_updated, 0);
    // R11/R9: masked-off chain-4 write leaves its flag clear
    load_bank(0);
    @(negedge clk);
    win_sel = 2'd0; chain4_en = 1'b1; oddeven_en = 1'b0; map_mask = 4'b0101;
    req_write = 1'b1; req_wdata = 8'h11; req_valid = 1'b1;
    for (int p = 0; p < 4; p++) begin
      req_addr = HA'(p);
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk("R11 masked flags", plane_updated, 4'b0101);

    // R12: back-pressure
    @(negedge clk);
    rsp_ready = 1'b0; chain4_en = 1'b0; req_write = 1'b0;
    req_addr = HA'(16); req_valid = 1'b1;
    @(negedge clk);
    chk("R12 first taken", rsp_valid, 1);
    chk("R12 ready low", req_ready, 0);
    req_addr = HA'(32);
    @(negedge clk);
    chk("R12 held addr", rsp_addr, 16);
    chk("R12 still blocked", req_ready, 0);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R12 next after drain", rsp_addr, 32);
    @(negedge clk);
    chk("R12 drained", rsp_valid, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule